// File: doc/BRIEF.md
# Priority Reference Selector with Force

This block picks which of fourteen candidate timing references feeds a DPLL. Each candidate lane carries a 4-bit priority and a validity flag from an external activity monitor. Every clock the selector ranks the usable lanes. It holds the chosen lane in a register and reports it as a 1-based index. It also raises a level flag when nothing is selected, and a one-cycle pulse when the reference in use has dropped out. The DPLL state machine uses that pulse to decide whether to enter holdover.

Software can force one lane through a 4-bit field. A forced lane ranks above every programmed priority. It is treated as good whatever its monitor says, so it is never reported as failed. Forcing does not by itself move the selection off a healthy current lane. A single revertive enable decides whether a better-ranked lane may pre-empt the current one. With revertive mode on, the forced lane is always taken.

The control path is a three-state machine with these states:
- `ST_NOREF`: nothing is selected.
- `ST_AUTO`: a lane chosen by ranking is selected.
- `ST_FORCED`: the selected lane is the forced one.

Each cycle takes one of these transitions:
- acquire: from `ST_NOREF` to a lane, when any lane is eligible.
- hold: keep the current lane.
- revert: move to a strictly better-ranked lane, in revertive mode only.
- lose: the current lane stops being eligible. The machine moves to the best remaining lane, or to `ST_NOREF` if there is none, and pulses the failure flag.

The destination state of acquire, revert and lose depends on the new lane:
- `ST_FORCED` if it matches the force field.
- `ST_AUTO` for any other lane.
- `ST_NOREF` if there is no lane.

Top module: `refsel_top`

## Requirements
- R1: After reset the outputs are `sel_idx_o`=0, `no_ref_o`=1 and `ref_failed_o`=0.
- R2: Lane k (0-based) is eligible when its valid bit is 1 and its priority field `ref_prio_i[4k+3:4k]` is non-zero. From `ST_NOREF` the block selects the eligible lane with the smallest priority value, with ties going to the lowest lane number. `sel_idx_o` shows k+1 from the clock edge after the inputs are applied.
- R3: A lane whose priority field is 0 is never chosen by ranking, even when its valid bit is 1.
- R4: With `revert_en_i`=0, a current lane that stays eligible is kept, even when a better-ranked lane becomes eligible.
- R5: With `revert_en_i`=1, the block moves to the best lane only when that lane's rank is strictly smaller than the rank of the current lane. An equal rank does not cause a switch.
- R6: When the current lane stops being eligible, the next edge selects the best remaining eligible lane, or 0 if there is none. `ref_failed_o` is 1 for exactly that one cycle.
- R7: When no lane is eligible and no lane is forced, the next edge gives `sel_idx_o`=0 and `no_ref_o`=1.
- R8: A force value f in 1..14 makes lane f-1 eligible whatever its valid bit and priority. Its rank is 0, above every programmed priority. With `revert_en_i`=1 it is selected on the next edge.
- R9: While the current lane is the forced lane, it is kept even with its valid bit at 0, and `ref_failed_o` stays 0.
- R10: Force values 0 and 15 both give automatic selection. No lane is forced.
- R11: With `revert_en_i`=0, setting a force value does not move the selection away from an eligible current lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_valid_i | input | 14 | Per-lane validity from the monitor |
| ref_prio_i | input | 56 | Per-lane priority, 4 bits per lane, lane k at [4k+3:4k]; 0 disables the lane |
| force_sel_i | input | 4 | 0 or 15 means automatic; f in 1..14 forces lane f-1 |
| revert_en_i | input | 1 | 1 lets a strictly better lane pre-empt the current one |
| sel_idx_o | output | 4 | Selected lane plus one; 0 when none |
| no_ref_o | output | 1 | 1 when no lane is selected |
| ref_failed_o | output | 1 | One-cycle pulse when the current lane is dropped as ineligible |

## Verification
Several directed patterns each separate one rule from its neighbours:
- Two lanes sharing the lowest priority separate the tie-break from the minimum search.
- A valid lane with priority 0 shows that the disable value is honoured.
- An equal-rank lane in revertive mode distinguishes strict from non-strict pre-emption.
- A better lane with revertive mode off shows that the current lane is held.

Forcing is tried on a healthy current lane with revertive mode off and then on. It is also tried on a forced lane whose valid bit drops, and with the two automatic codes 0 and 15. These runs show that force only raises rank and suppresses failure.

A long run of seeded random valid, priority, force and revert patterns is then compared each cycle against a bench model of the rules. The run mixes lane loss, reacquisition and pre-emption.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
    typedef enum logic [1:0] {
        ST_NOREF  = 2'd0,
        ST_AUTO   = 2'd1,
        ST_FORCED = 2'd2
    } sel_state_t;
endpackage

// File: rtl/refsel_rank.sv
module refsel_rank #(
    parameter int N_REF  = 14,
    parameter int PRIO_W = 4,
    parameter int IDX_W  = 4
) (
    input  logic [N_REF-1:0]        valid_i,
    input  logic [N_REF*PRIO_W-1:0] prio_i,
    input  logic [IDX_W-1:0]        force_sel_i,
    output logic [N_REF-1:0]        elig_o,
    output logic [N_REF*PRIO_W-1:0] rank_o
);
    // Per-lane eligibility and effective rank; a forced lane ranks 0.
    for (genvar g = 0; g < N_REF; g++) begin : g_lane
        logic [PRIO_W-1:0] lane_prio;
        logic              force_hit;
        assign lane_prio = prio_i[g*PRIO_W +: PRIO_W];
        assign force_hit = (force_sel_i == IDX_W'(g + 1));
        assign elig_o[g] = force_hit | (valid_i[g] & (lane_prio != '0));
        assign rank_o[g*PRIO_W +: PRIO_W] = force_hit ? '0 : lane_prio;
    end
endmodule

// File: rtl/refsel_pick.sv
module refsel_pick #(
    parameter int N_REF  = 14,
    parameter int PRIO_W = 4,
    parameter int IDX_W  = 4
) (
    input  logic [N_REF-1:0]        elig_i,
    input  logic [N_REF*PRIO_W-1:0] rank_i,
    output logic                    found_o,
    output logic [IDX_W-1:0]        idx_o,
    output logic [PRIO_W-1:0]       rank_o
);
    // Minimum search; strict compare keeps the lowest lane on ties.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        rank_o  = '1;
        for (int i = 0; i < N_REF; i++) begin
            if (elig_i[i] && (!found_o || (rank_i[i*PRIO_W +: PRIO_W] < rank_o))) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i + 1);
                rank_o  = rank_i[i*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/refsel_fsm.sv
module refsel_fsm
    import refsel_pkg::*;
#(
    parameter int N_REF  = 14,
    parameter int PRIO_W = 4,
    parameter int IDX_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_REF-1:0]        elig_i,
    input  logic [N_REF*PRIO_W-1:0] rank_i,
    input  logic                    best_found_i,
    input  logic [IDX_W-1:0]        best_idx_i,
    input  logic [PRIO_W-1:0]       best_rank_i,
    input  logic [IDX_W-1:0]        force_sel_i,
    input  logic                    revert_en_i,
    output logic [IDX_W-1:0]        sel_idx_o,
    output logic                    no_ref_o,
    output logic                    ref_failed_o
);
    sel_state_t        state_q, state_d;
    logic [IDX_W-1:0]  cur_q, cur_d;
    logic              fail_q, fail_d;
    logic              cur_elig;
    logic [PRIO_W-1:0] cur_rank;

    // Next-state and next-selection logic.
    always_comb begin
        cur_elig = 1'b0;
        cur_rank = '1;
        for (int i = 0; i < N_REF; i++) begin
            if (cur_q == IDX_W'(i + 1)) begin
                cur_elig = elig_i[i];
                cur_rank = rank_i[i*PRIO_W +: PRIO_W];
            end
        end
        cur_d  = cur_q;
        fail_d = 1'b0;
        unique case (state_q)
            ST_NOREF: begin
                if (best_found_i) begin
                    cur_d = best_idx_i;                          // acquire
                end
            end
            ST_AUTO, ST_FORCED: begin
                if (!cur_elig) begin
                    fail_d = 1'b1;                               // lose
                    cur_d  = best_found_i ? best_idx_i : '0;
                end else if (revert_en_i && best_found_i && (best_rank_i < cur_rank)) begin
                    cur_d = best_idx_i;                          // revert
                end
            end
            default: cur_d = '0;
        endcase
        if (cur_d == '0) begin
            state_d = ST_NOREF;
        end else if (cur_d == force_sel_i) begin
            state_d = ST_FORCED;
        end else begin
            state_d = ST_AUTO;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_NOREF;
            cur_q   <= '0;
            fail_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
            fail_q  <= fail_d;
        end
    end

    // Outputs.
    always_comb begin
        sel_idx_o    = cur_q;
        no_ref_o     = (state_q == ST_NOREF);
        ref_failed_o = fail_q;
    end

    assert_sel_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sel_idx_o <= IDX_W'(N_REF));

    assert_hold_nonrevert_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!revert_en_i && (state_q != ST_NOREF) && cur_elig) |=> (sel_idx_o == $past(sel_idx_o)));

    assert_fail_needs_ref_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ref_failed_o |-> ($past(sel_idx_o) != '0));

    assert_forced_no_fail_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((force_sel_i != '0) && (sel_idx_o == force_sel_i)) |=> !ref_failed_o);
endmodule

// File: rtl/refsel_top.sv
module refsel_top #(
    parameter int N_REF  = 14,
    parameter int PRIO_W = 4,
    localparam int IDX_W = $clog2(N_REF + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_REF-1:0]        ref_valid_i,
    input  logic [N_REF*PRIO_W-1:0] ref_prio_i,
    input  logic [IDX_W-1:0]        force_sel_i,
    input  logic                    revert_en_i,
    output logic [IDX_W-1:0]        sel_idx_o,
    output logic                    no_ref_o,
    output logic                    ref_failed_o
);
    logic [N_REF-1:0]        elig;
    logic [N_REF*PRIO_W-1:0] rank;
    logic                    best_found;
    logic [IDX_W-1:0]        best_idx;
    logic [PRIO_W-1:0]       best_rank;

    refsel_rank #(.N_REF(N_REF), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_rank (
        .valid_i     (ref_valid_i),
        .prio_i      (ref_prio_i),
        .force_sel_i (force_sel_i),
        .elig_o      (elig),
        .rank_o      (rank)
    );

    refsel_pick #(.N_REF(N_REF), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_pick (
        .elig_i  (elig),
        .rank_i  (rank),
        .found_o (best_found),
        .idx_o   (best_idx),
        .rank_o  (best_rank)
    );

    refsel_fsm #(.N_REF(N_REF), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .elig_i       (elig),
        .rank_i       (rank),
        .best_found_i (best_found),
        .best_idx_i   (best_idx),
        .best_rank_i  (best_rank),
        .force_sel_i  (force_sel_i),
        .revert_en_i  (revert_en_i),
        .sel_idx_o    (sel_idx_o),
        .no_ref_o     (no_ref_o),
        .ref_failed_o (ref_failed_o)
    );

    assert_empty_noref_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (elig == '0) |=> no_ref_o);
endmodule

// File: tb/refsel_top_tb.sv
`timescale 1ns/100ps
module refsel_top_tb;
    localparam int N = 14;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [N-1:0]   valid;
    logic [N*4-1:0] prio_flat;
    logic [3:0]  force_sel;
    logic        revert;
    logic [3:0]  sel_idx;
    logic        no_ref;
    logic        failed;

    logic [3:0]  prio_a [N];
    int          m_sel;
    int          exp_fail;
    int          checks = 0;
    int          errors = 0;
    bit          done = 0;

    always #2.5 clk = ~clk;

    refsel_top u_dut (
        .clk(clk), .rst_n(rst_n), .ref_valid_i(valid), .ref_prio_i(prio_flat),
        .force_sel_i(force_sel), .revert_en_i(revert),
        .sel_idx_o(sel_idx), .no_ref_o(no_ref), .ref_failed_o(failed)
    );

    function automatic bit lane_elig(int k);
        if (force_sel == 4'(k + 1)) return 1'b1;
        return valid[k] && (prio_a[k] != 0);
    endfunction

    function automatic int lane_rank(int k);
        if (force_sel == 4'(k + 1)) return 0;
        return int'(prio_a[k]);
    endfunction

    // Expected next selection from the requirements.
    task automatic model_step();
        int best = 0;
        int brank = 99;
        exp_fail = 0;
        for (int k = 0; k < N; k++) begin
            if (lane_elig(k) && lane_rank(k) < brank) begin
                best = k + 1;
                brank = lane_rank(k);
            end
        end
        if (m_sel == 0) begin
            m_sel = best;
        end else if (!lane_elig(m_sel - 1)) begin
            exp_fail = 1;
            m_sel = best;
        end else if (revert && best != 0 && brank < lane_rank(m_sel - 1)) begin
            m_sel = best;
        end
    endtask

    task automatic pack();
        for (int k = 0; k < N; k++) prio_flat[k*4 +: 4] = prio_a[k];
    endtask

    // Inputs are set at the falling edge; outputs checked 1 ns after the rising edge.
    task automatic step(string tag);
        pack();
        model_step();
        @(posedge clk);
        #1;
        checks++;
        if (sel_idx !== 4'(m_sel) || no_ref !== (m_sel == 0) || failed !== exp_fail[0]) begin
            errors++;
            $display("FAIL %s: sel=%0d noref=%0b fail=%0b expected sel=%0d noref=%0b fail=%0b",
                     tag, sel_idx, no_ref, failed, m_sel, (m_sel == 0), exp_fail[0]);
        end
        @(negedge clk);
    endtask

    task automatic clear_all();
        valid = '0;
        force_sel = 4'd0;
        revert = 1'b0;
        for (int k = 0; k < N; k++) prio_a[k] = 4'd0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        m_sel = 0;
        pack();
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: sel=%0d expected finish", sel_idx);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        clear_all();
        do_reset();
        checks++;
        if (sel_idx !== 4'd0 || no_ref !== 1'b1 || failed !== 1'b0) begin
            errors++;
            $display("FAIL R1: sel=%0d noref=%0b fail=%0b expected 0 1 0", sel_idx, no_ref, failed);
        end

        step("R7 nothing eligible");
        prio_a[0] = 4'd0; valid[0] = 1'b1;
        step("R3 zero priority lane ignored");
        prio_a[2] = 4'd5; prio_a[6] = 4'd2; prio_a[9] = 4'd2;
        valid[2] = 1'b1; valid[6] = 1'b1; valid[9] = 1'b1;
        step("R2 lowest value, tie to lowest lane");
        checks++;
        if (sel_idx !== 4'd7) begin
            errors++;
            $display("FAIL R2: sel=%0d expected 7", sel_idx);
        end
        prio_a[1] = 4'd1; valid[1] = 1'b1;
        step("R4 non-revertive hold");
        revert = 1'b1;
        step("R5 revert to better lane");
        prio_a[3] = 4'd1; valid[3] = 1'b1;
        step("R5 equal rank no switch");
        valid[1] = 1'b0;
        step("R6 lose current, reselect with pulse");
        step("R6 pulse lasts one cycle");
        revert = 1'b0; force_sel = 4'd11;
        step("R11 force without revert keeps current");
        revert = 1'b1;
        step("R8 forced lane taken in revertive mode");
        valid[10] = 1'b0;
        step("R9 forced lane kept while invalid");
        step("R9 no failure reported");
        force_sel = 4'd15;
        step("R10 code 15 is automatic");
        force_sel = 4'd0; valid = '0;
        step("R10 code 0 is automatic, R7 empty");
        step("R7 stays empty");

        for (int n = 0; n < 4000; n++) begin
            for (int k = 0; k < N; k++) begin
                if ($urandom_range(0, 7) == 0) valid[k] = ~valid[k];
                if ($urandom_range(0, 31) == 0) prio_a[k] = 4'($urandom_range(0, 15));
            end
            if ($urandom_range(0, 15) == 0) force_sel = 4'($urandom_range(0, 15));
            if ($urandom_range(0, 15) == 0) revert = ~revert;
            if ($urandom_range(0, 63) == 0) valid = '0;
            step("R2/R4/R5/R6/R8 random");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule